// File: doc/BRIEF.md
# PDM Microphone Digital Output Controller

This block is the digital back end of a one-bit pulse-density microphone. A host supplies a bit clock and an edge-select level; the block takes the modulator's bit stream from an input port, presents one bit per bit-clock period on a shared data line, and releases the line for the other half of the period. Two such blocks, strapped to opposite edge-select levels, can then share one wire in a stereo pair.

The block also decides by itself whether it should be running. It counts bit-clock rising edges over a fixed window of a free-running reference clock. A fast clock wakes it, a slow or stopped clock puts it to sleep, and counts between the two thresholds leave the state as it is. After waking, a settle interval of whole windows passes before the first bit is driven. The data line is modelled as a data bit plus an output-enable, so that a pad cell outside the block makes the high-impedance state.

Top module: `pdm_mic_ctrl`

## Requirements
- R1: After reset, `pwr_state` is 0 (sleep) and `pdm_oe` is 0.
- R2: `pwr_state` encodes sleep as 0, waking as 1 and active as 2, and never takes the value 3.
- R3: In sleep, a window that counts at least `WAKE_TH` bit-clock rising edges moves the state to waking (with the defaults, a clock period of 300 reference cycles or shorter).
- R4: In waking or active, a window that counts at most `SLEEP_TH` rising edges moves the state to sleep; a stopped bit clock and a clock with exactly one rising edge per window both lead to sleep.
- R5: A window count above `SLEEP_TH` and below `WAKE_TH` leaves the state unchanged, whether asleep or active.
- R6: Waking becomes active after `SETTLE_WIN` further windows whose counts reach `WAKE_TH`.
- R7: `pdm_oe` stays 0 in sleep and in waking, and falls to 0 within one reference cycle of leaving active.
- R8: With `edge_sel` at 0, the bit on `mod_bit` is placed on `pdm_dat` and `pdm_oe` rises within four reference cycles after a falling bit-clock edge; `pdm_oe` drops at the following rising edge.
- R9: With `edge_sel` at 1, the roles of the edges are swapped: drive after a rising edge, release at the falling edge.
- R10: The release follows the raw bit-clock transition without waiting for a reference-clock edge (`pdm_oe` is 0 one nanosecond after the release edge).
- R11: The first bit after entering active is driven only at a drive edge that follows the entry; a stopped clock in the drive half keeps the last bit on the line until the block falls asleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk | input | 1 | Bit clock from the host |
| edge_sel | input | 1 | 0: drive after falling edge; 1: drive after rising edge |
| mod_bit | input | 1 | Modulator bit stream |
| pdm_dat | output | 1 | Data bit for the shared line |
| pdm_oe | output | 1 | Output enable for the shared line (0 = high impedance) |
| pwr_state | output | 2 | 0 sleep, 1 waking, 2 active |

## Verification
The end-of-window sleep decision and a data drive event can land in the same reference cycle, since both come from the same synchronised bit clock. The bench provokes this by stopping the bit clock just after a drive edge while active, so that the line is still held and the next window decides to sleep. It judges that the held bit stays on the line until the state reads 0 and that the enable is then low, and it also checks that a new active period drives nothing before its first drive edge.

// File: rtl/pdm_mic_pkg.sv
`timescale 1ns/1ps
package pdm_mic_pkg;
   typedef enum logic [1:0] {
      ST_SLEEP  = 2'd0,
      ST_WAKE   = 2'd1,
      ST_ACTIVE = 2'd2
   } pwr_state_t;
endpackage

// File: rtl/pdm_clk_sync.sv
`timescale 1ns/1ps
module pdm_clk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise,
   output logic fall
);
   logic [STAGES:0] chain;
   logic            prev_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("pdm_clk_sync: STAGES must be at least 2");
   end

   assign chain[0] = async_in;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i+1] <= 1'b0;
         else        chain[i+1] <= chain[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain[STAGES];
   end

   assign rise = chain[STAGES] & ~prev_q;
   assign fall = ~chain[STAGES] & prev_q;

   a_r3_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise && fall));
   a_r3_no_double_rise: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/pdm_rate_mon.sv
`timescale 1ns/1ps
module pdm_rate_mon #(
   parameter int WIN = 2000,
   localparam int WW = $clog2(WIN),
   localparam int CW = $clog2(WIN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rise,
   output logic          win_done,
   output logic [CW-1:0] win_cnt
);
   localparam logic [WW-1:0] WLAST = WW'(WIN - 1);

   logic [WW-1:0] tick_q;
   logic [CW-1:0] edge_q;

   if (WIN < 4) begin : g_bad_win
      $error("pdm_rate_mon: WIN must be at least 4");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q   <= '0;
         edge_q   <= '0;
         win_done <= 1'b0;
         win_cnt  <= '0;
      end else begin
         win_done <= 1'b0;
         if (tick_q == WLAST) begin
            tick_q   <= '0;
            edge_q   <= '0;
            win_done <= 1'b1;
            win_cnt  <= edge_q + CW'(rise);
         end else begin
            tick_q <= tick_q + 1'b1;
            edge_q <= edge_q + CW'(rise);
         end
      end
   end

   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      win_done |=> !win_done);
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      win_done |-> (32'(win_cnt) <= WIN / 2 + 1));
endmodule

// File: rtl/pdm_pwr_fsm.sv
`timescale 1ns/1ps
module pdm_pwr_fsm
   import pdm_mic_pkg::*;
#(
   parameter int CW         = 11,
   parameter int WAKE_TH    = 6,
   parameter int SLEEP_TH   = 1,
   parameter int SETTLE_WIN = 2,
   localparam int SW = (SETTLE_WIN > 1) ? $clog2(SETTLE_WIN) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          win_done,
   input  logic [CW-1:0] win_cnt,
   output pwr_state_t    state
);
   localparam logic [CW-1:0] WAKE_V  = CW'(WAKE_TH);
   localparam logic [CW-1:0] SLEEP_V = CW'(SLEEP_TH);
   localparam logic [SW-1:0] SLAST   = SW'(SETTLE_WIN - 1);

   logic [SW-1:0] settle_q;
   logic          is_fast, is_slow;

   if (WAKE_TH <= SLEEP_TH) begin : g_bad_th
      $error("pdm_pwr_fsm: WAKE_TH must exceed SLEEP_TH");
   end
   if (SETTLE_WIN < 1) begin : g_bad_settle
      $error("pdm_pwr_fsm: SETTLE_WIN must be at least 1");
   end

   assign is_fast = (win_cnt >= WAKE_V);
   assign is_slow = (win_cnt <= SLEEP_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_SLEEP;
         settle_q <= '0;
      end else if (win_done) begin
         unique case (state)
            ST_SLEEP: begin
               settle_q <= '0;
               if (is_fast) state <= ST_WAKE;
            end
            ST_WAKE: begin
               if (is_slow) state <= ST_SLEEP;
               else if (is_fast) begin
                  if (settle_q == SLAST) state <= ST_ACTIVE;
                  else                   settle_q <= settle_q + 1'b1;
               end
            end
            ST_ACTIVE: begin
               if (is_slow) state <= ST_SLEEP;
            end
            default: state <= ST_SLEEP;
         endcase
      end
   end

   a_r2_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
      state != 2'd3);
   a_r3_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_SLEEP && state == ST_WAKE) |->
         ($past(win_done) && $past(win_cnt) >= WAKE_V));
   a_r4_slow_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
      (win_done && win_cnt <= SLEEP_V) |=> state == ST_SLEEP);
   a_r5_band_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (win_done && win_cnt > SLEEP_V && win_cnt < WAKE_V) |=> $stable(state));
   a_r6_active_via_wake: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) != ST_ACTIVE && state == ST_ACTIVE) |-> $past(state) == ST_WAKE);
endmodule

// File: rtl/pdm_out_stage.sv
`timescale 1ns/1ps
module pdm_out_stage #(
   parameter bit RELEASE_ASYNC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic edge_sel,
   input  logic bclk,
   input  logic rise,
   input  logic fall,
   input  logic mod_bit,
   output logic pdm_dat,
   output logic pdm_oe
);
   logic drive_evt, rel_evt;
   logic oe_q;

   assign drive_evt = edge_sel ? rise : fall;
   assign rel_evt   = edge_sel ? fall : rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q    <= 1'b0;
         pdm_dat <= 1'b0;
      end else if (!active) begin
         oe_q <= 1'b0;
      end else if (drive_evt) begin
         oe_q    <= 1'b1;
         pdm_dat <= mod_bit;
      end else if (rel_evt) begin
         oe_q <= 1'b0;
      end
   end

   if (RELEASE_ASYNC) begin : g_async_release
      assign pdm_oe = oe_q & (edge_sel ? bclk : ~bclk);
   end else begin : g_sync_release
      assign pdm_oe = oe_q;
   end

   a_r7_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !$past(active)) |-> !oe_q);
   a_r8_drive_load: assert property (@(posedge clk) disable iff (!rst_n)
      (active && drive_evt) |=> (oe_q && pdm_dat == $past(mod_bit)));
   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_evt && !drive_evt) |=> !oe_q);
endmodule

// File: rtl/pdm_mic_ctrl.sv
`timescale 1ns/1ps
module pdm_mic_ctrl
   import pdm_mic_pkg::*;
#(
   parameter int WIN           = 2000,
   parameter int WAKE_TH       = 6,
   parameter int SLEEP_TH      = 1,
   parameter int SETTLE_WIN    = 2,
   parameter int SYNC_STAGES   = 2,
   parameter bit RELEASE_ASYNC = 1'b1,
   localparam int CW = $clog2(WIN + 1)
) (
   input  logic       ref_clk,
   input  logic       rst_n,
   input  logic       bclk,
   input  logic       edge_sel,
   input  logic       mod_bit,
   output logic       pdm_dat,
   output logic       pdm_oe,
   output logic [1:0] pwr_state
);
   logic          rise, fall, win_done;
   logic [CW-1:0] win_cnt;
   pwr_state_t    state;

   if (WAKE_TH > WIN / 2) begin : g_bad_wake
      $error("pdm_mic_ctrl: WAKE_TH unreachable within one window");
   end

   pdm_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(ref_clk), .rst_n(rst_n), .async_in(bclk), .rise(rise), .fall(fall));

   pdm_rate_mon #(.WIN(WIN)) u_rate (
      .clk(ref_clk), .rst_n(rst_n), .rise(rise),
      .win_done(win_done), .win_cnt(win_cnt));

   pdm_pwr_fsm #(.CW(CW), .WAKE_TH(WAKE_TH), .SLEEP_TH(SLEEP_TH),
                 .SETTLE_WIN(SETTLE_WIN)) u_fsm (
      .clk(ref_clk), .rst_n(rst_n), .win_done(win_done),
      .win_cnt(win_cnt), .state(state));

   pdm_out_stage #(.RELEASE_ASYNC(RELEASE_ASYNC)) u_out (
      .clk(ref_clk), .rst_n(rst_n), .active(state == ST_ACTIVE),
      .edge_sel(edge_sel), .bclk(bclk), .rise(rise), .fall(fall),
      .mod_bit(mod_bit), .pdm_dat(pdm_dat), .pdm_oe(pdm_oe));

   assign pwr_state = state;

   a_r7_oe_needs_active: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (state != ST_ACTIVE && $past(state) != ST_ACTIVE) |-> !pdm_oe);
endmodule

// File: tb/pdm_mic_ctrl_bench.sv
`timescale 1ns/1ps
module pdm_mic_ctrl_bench;
   localparam int WINC = 2000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bclk = 1'b0;
   logic       edge_sel = 1'b0;
   logic       mod_bit = 1'b0;
   logic       pdm_dat, pdm_oe;
   logic [1:0] pwr_state;
   int         bhalf = 0;
   int         n_chk = 0;
   int         n_bad = 0;

   pdm_mic_ctrl u_pdm_mic_ctrl (
      .ref_clk(clk), .rst_n(rst_n), .bclk(bclk), .edge_sel(edge_sel),
      .mod_bit(mod_bit), .pdm_dat(pdm_dat), .pdm_oe(pdm_oe),
      .pwr_state(pwr_state));

   always #5 clk = ~clk;

   initial begin
      forever begin
         if (bhalf == 0) @(posedge clk);
         else begin
            repeat (bhalf) @(posedge clk);
            #1 bclk = ~bclk;
         end
      end
   end

   task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_win(input int n);
      repeat (n * WINC) @(posedge clk);
      @(negedge clk);
   endtask

   // columns: bit-clock half period (ref cycles, 0 = stopped), windows to wait, expected state
   localparam int NV = 9;
   localparam int VEC [NV][3] = '{
      '{0,    2, 0},   // R4 stopped clock stays asleep
      '{40,   6, 2},   // R3 R6 fast clock wakes and settles
      '{4000, 3, 0},   // R4 slow clock sleeps
      '{200,  4, 0},   // R5 band count holds sleep
      '{40,   6, 2},   // R3 R6 wake again
      '{200,  4, 2},   // R5 band count holds active
      '{0,    3, 0},   // R4 stop from active
      '{150,  6, 2},   // R3 count 6 or 7 at wake threshold
      '{1000, 3, 0}    // R4 exactly one edge per window
   };

   task automatic data_phase(input logic sel, input logic [7:0] pat);
      edge_sel = sel;
      for (int i = 0; i < 8; i++) begin
         if (sel) @(negedge bclk); else @(posedge bclk);
         #1;
         chk(sel ? "R9 released" : "R8 released", {1'b0, pdm_oe}, 2'd0);
         mod_bit = pat[i];
         if (sel) @(posedge bclk); else @(negedge bclk);
         repeat (4) @(negedge clk);
         chk(sel ? "R9 oe driven" : "R8 oe driven", {1'b0, pdm_oe}, 2'd1);
         chk(sel ? "R9 data bit" : "R8 data bit", {1'b0, pdm_dat}, {1'b0, pat[i]});
         if (sel) @(negedge bclk); else @(posedge bclk);
         #1;
         chk("R10 immediate release", {1'b0, pdm_oe}, 2'd0);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset state", pwr_state, 2'd0);
      chk("R1 reset oe", {1'b0, pdm_oe}, 2'd0);
      rst_n = 1'b1;

      // R7 R11: no driving while waking
      bhalf = 40;
      for (int k = 0; k < 3 * WINC && pwr_state != 2'd1; k++) @(negedge clk);
      chk("R3 entered waking", pwr_state, 2'd1);
      for (int k = 0; k < WINC; k++) begin
         @(negedge clk);
         if (pdm_oe !== 1'b0) begin
            chk("R7 oe low while waking", {1'b0, pdm_oe}, 2'd0);
            break;
         end
      end
      chk("R2 waking code", pwr_state, 2'd1);
      bhalf = 0;
      wait_win(3);

      for (int v = 0; v < NV; v++) begin
         bhalf = VEC[v][0];
         wait_win(VEC[v][1]);
         chk("R3 R4 R5 R6 table state", pwr_state, 2'(VEC[v][2]));
         if (VEC[v][2] != 2) chk("R7 oe idle", {1'b0, pdm_oe}, 2'd0);
      end

      // R11: right after entering active, nothing driven before a drive edge
      bhalf = 40;
      edge_sel = 1'b0;
      for (int k = 0; k < 8 * WINC && pwr_state != 2'd2; k++) begin
         @(negedge clk);
         if (pwr_state == 2'd2) chk("R11 no early drive", {1'b0, pdm_oe}, 2'd0);
      end
      chk("R6 active reached", pwr_state, 2'd2);

      data_phase(1'b0, 8'b1011_0010);
      data_phase(1'b1, 8'b0110_1101);

      // R11 / collision: stop clock just after a drive edge, held bit until sleep
      edge_sel = 1'b0;
      mod_bit = 1'b1;
      @(negedge bclk);
      bhalf = 0;
      repeat (6) @(negedge clk);
      chk("R11 held bit oe", {1'b0, pdm_oe}, 2'd1);
      chk("R11 held bit data", {1'b0, pdm_dat}, 2'd1);
      wait_win(3);
      chk("R4 stopped sleeps", pwr_state, 2'd0);
      chk("R7 oe dropped on sleep", {1'b0, pdm_oe}, 2'd0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule